// File: doc/BRIEF.md
# SPI EEPROM Page-Write Command Controller

This block is the slave-side logic that accepts the serial page-write command of an SPI EEPROM. It sits behind the chip-select, serial-clock and serial-data pins, all synchronous to the system clock `clk`. It decodes each frame and gathers the data bytes of a write into a page-sized buffer. When chip select is released, it either starts one self-timed write cycle that copies the gathered bytes to a parallel array port, or it discards the whole command.

A one-byte write-enable command arms a latch that the write needs. While a write cycle runs, the block drives `busy` high for a fixed number of clock cycles set by a parameter. Two block-protect inputs fence off part of the array.

Top module: `spi_page_writer`

## Requirements
- R1: After reset `busy` is low, `mem_we` is low, and the write-enable latch is clear, so a write sent before any enable command is refused.
- R2: A frame made of exactly the 8 bits 0x06, with chip select rising when no write cycle is running, sets the write-enable latch.
- R3: A write frame carries, on `mosi` sampled at rising `sck` while `cs_n` is low and MSB first, the opcode 0x02, then a 16-bit address, then one or more data bytes. When accepted, data byte k lands at in-page offset (address offset + k).
- R4: A write is committed only if `cs_n` rises after a whole number of data bytes (at least one). Any other length writes nothing to the array. Every refused write frame clears the write-enable latch.
- R5: Only the in-page offset (low log2(PAGE_BYTES) bits) advances per byte. Past the last byte of the page it wraps to offset 0, and a later byte overwrites an earlier one at the same offset.
- R6: A write frame is refused when the write-enable latch is clear.
- R7: A write frame is refused when a write cycle is running at any point between its `cs_n` fall and its `cs_n` rise.
- R8: Block-protect `bp` refuses writes to the protected part of the array: 00 protects nothing, 01 protects the top quarter, 10 the top half, 11 everything.
- R9: An accepted write raises `busy` in the cycle after `cs_n` rises and holds it for exactly WRITE_CYCLES cycles. During the first PAGE_BYTES of those cycles the port writes each received offset once, in ascending offset order, one per cycle.
- R10: The write-enable latch clears when a write cycle ends, so a second write needs a new enable command.
- R11: Address bits above ADDR_BITS are ignored.
- R12: A frame with any other opcode writes nothing and leaves the write-enable latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| bp | input | 2 | Block-protect setting |
| busy | output | 1 | Write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_BITS | Array byte address |
| mem_data | output | 8 | Array write data |

## Verification
A bad bit counter or offset register shows up in the first write cycle after the fault. It appears as a strobe at the wrong address, a byte missing or doubled after a page wrap, or data shifted by a bit. A write-enable latch or busy flag holding a stale value shows one frame later, as a commit that should have been refused or a refusal that should have committed. Comparing `busy` and the array port on every cycle against a frame-level model catches these within a write-cycle length of the cause.

// File: rtl/spi_page_writer.sv
`timescale 1ns/1ps
module spi_page_writer #(
  parameter int ADDR_BITS    = 15,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 100,
  parameter logic [7:0] OPC_WRITE = 8'h02,
  parameter logic [7:0] OPC_WREN  = 8'h06
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sck,
  input  logic                 cs_n,
  input  logic                 mosi,
  input  logic [1:0]           bp,
  output logic                 busy,
  output logic                 mem_we,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [7:0]           mem_data
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_BITS - OFF_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DATA, S_WREN, S_SKIP} st_t;

  st_t                  st;
  logic                 sck_q, cs_q;
  logic [3:0]           bit_cnt;
  logic [6:0]           shreg;
  logic [ADDR_BITS-1:0] addr_r;
  logic [OFF_W-1:0]     off;
  logic                 got_byte, seen_busy, wel;
  logic [7:0]           pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [CNT_W-1:0]     wcnt;
  logic [OFF_W:0]       scan;
  logic [PG_W-1:0]      page_q;

  wire [7:0] sh_n     = {shreg, mosi};
  wire       sck_rise = !cs_n && sck && !sck_q;
  wire       cs_fall  = !cs_n && cs_q;
  wire       cs_rise  = cs_n && !cs_q;
  wire       load     = sck_rise && st == S_DATA && bit_cnt == 4'd7 && !seen_busy && !busy;

  wire prot = (bp == 2'b11) ||
              (bp == 2'b10 && addr_r[ADDR_BITS-1]) ||
              (bp == 2'b01 && &addr_r[ADDR_BITS-1 -: 2]);

  wire commit    = cs_rise && st == S_DATA && bit_cnt == 4'd0 && got_byte &&
                   wel && !seen_busy && !busy && !prot;
  wire wr_reject = cs_rise && (st == S_ADDR || st == S_DATA) && !commit;
  wire wren_ok   = cs_rise && st == S_WREN && !busy;
  wire cyc_end   = busy && wcnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      bit_cnt   <= '0;
      shreg     <= '0;
      addr_r    <= '0;
      off       <= '0;
      got_byte  <= 1'b0;
      seen_busy <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_fall) begin
        st        <= S_OPC;
        bit_cnt   <= '0;
        got_byte  <= 1'b0;
        seen_busy <= busy;
      end else if (!cs_n) begin
        if (busy) seen_busy <= 1'b1;
        if (sck_rise) begin
          shreg <= sh_n[6:0];
          case (st)
            S_OPC: begin
              if (bit_cnt == 4'd7) begin
                bit_cnt <= '0;
                st <= (sh_n == OPC_WRITE) ? S_ADDR :
                      (sh_n == OPC_WREN)  ? S_WREN : S_SKIP;
              end else bit_cnt <= bit_cnt + 4'd1;
            end
            S_ADDR: begin
              addr_r <= {addr_r[ADDR_BITS-2:0], mosi};
              if (bit_cnt == 4'd15) begin
                bit_cnt <= '0;
                off     <= {addr_r[OFF_W-2:0], mosi};
                st      <= S_DATA;
              end else bit_cnt <= bit_cnt + 4'd1;
            end
            S_DATA: begin
              if (bit_cnt == 4'd7) begin
                bit_cnt  <= '0;
                got_byte <= 1'b1;
                off      <= off + 1'b1;
              end else bit_cnt <= bit_cnt + 4'd1;
            end
            S_WREN:  st <= S_SKIP;
            default: ;
          endcase
        end
      end else begin
        st <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) pbuf[off] <= sh_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid <= '0;
    else if (cs_fall && !busy) valid <= '0;
    else if (load) valid[off] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wcnt   <= '0;
      scan   <= '0;
      page_q <= '0;
    end else if (busy) begin
      if (wcnt == '0) busy <= 1'b0;
      else wcnt <= wcnt - 1'b1;
      if (!scan[OFF_W]) scan <= scan + 1'b1;
    end else if (commit) begin
      busy   <= 1'b1;
      wcnt   <= CNT_W'(WRITE_CYCLES - 1);
      scan   <= '0;
      page_q <= addr_r[ADDR_BITS-1:OFF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wel <= 1'b0;
    else if (wr_reject || cyc_end) wel <= 1'b0;
    else if (wren_ok) wel <= 1'b1;
  end

  assign mem_we   = busy && !scan[OFF_W] && valid[scan[OFF_W-1:0]];
  assign mem_addr = {page_q, scan[OFF_W-1:0]};
  assign mem_data = pbuf[scan[OFF_W-1:0]];
endmodule

// File: rtl/spi_page_writer_chk.sv
`timescale 1ns/1ps
module spi_page_writer_chk #(
  parameter int ADDR_BITS    = 15,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 100
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 busy,
  input logic                 mem_we,
  input logic [ADDR_BITS-1:0] mem_addr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [31:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else run <= busy ? run + 32'd1 : 32'd0;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R9
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < WRITE_CYCLES); // R9
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == WRITE_CYCLES); // R9
  AST_START_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2))); // R4
  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr > $past(mem_addr)); // R5
  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      mem_addr[ADDR_BITS-1:OFF_W] == $past(mem_addr[ADDR_BITS-1:OFF_W])); // R5
endmodule

bind spi_page_writer spi_page_writer_chk #(
  .ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/spi_page_writer_bench.sv
`timescale 1ns/1ps
module spi_page_writer_bench;
  localparam int AB = 15;
  localparam int PB = 64;
  localparam int WC = 100;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic [1:0] bp = 2'b00;
  logic busy, mem_we;
  logic [AB-1:0] mem_addr;
  logic [7:0] mem_data;

  spi_page_writer #(.ADDR_BITS(AB), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) u_spi_page_writer (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .bp(bp),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural frame-level model
  logic mq[$];
  bit   m_busy, m_wel, m_fb, m_csp, m_sckp;
  int   m_cnt, m_scan, m_page;
  bit   ev [PB];
  logic [7:0] ed [PB];

  function automatic logic [7:0] qbyte(input int s);
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[6:0], mq[s+i]};
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wel = 0; m_fb = 0; m_csp = 1; m_sckp = 0;
      m_cnt = 0; m_scan = 0; m_page = 0;
      mq.delete();
    end else begin
      bit commit, wren, rej;
      commit = 0; wren = 0; rej = 0;
      if (!cs_n && m_csp) begin
        mq.delete(); m_fb = m_busy;
      end else if (!cs_n) begin
        if (m_busy) m_fb = 1;
        if (sck && !m_sckp) mq.push_back(mosi);
      end else if (!m_csp) begin
        int n;
        n = mq.size();
        if (n >= 8) begin
          logic [7:0] op;
          op = qbyte(0);
          if (op == 8'h06 && n == 8 && !m_busy) wren = 1;
          if (op == 8'h02) begin
            int a, top;
            bit prot;
            a = 0; prot = 0;
            if (n >= 24) a = ((int'(qbyte(8)) << 8) | int'(qbyte(16))) % (1 << AB);
            top = a >> (AB - 2);
            prot = (bp == 3) || (bp == 2 && top >= 2) || (bp == 1 && top == 3);
            if (n >= 32 && n % 8 == 0 && m_wel && !m_fb && !m_busy && !prot) begin
              commit = 1;
              for (int i = 0; i < PB; i++) ev[i] = 0;
              for (int k = 0; k < (n - 24) / 8; k++) begin
                ev[(a + k) % PB] = 1;
                ed[(a + k) % PB] = qbyte(24 + 8 * k);
              end
              m_page = a / PB;
            end else rej = 1;
          end
        end
      end
      if (rej || (m_busy && m_cnt == 0)) m_wel = 0;
      else if (wren) m_wel = 1;
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
        if (m_scan < PB) m_scan++;
      end else if (commit) begin
        m_busy = 1; m_cnt = WC - 1; m_scan = 0;
      end
      m_csp = cs_n; m_sckp = sck;
    end
  end

  // per-cycle comparison, port mirror, busy length
  logic [7:0] mirror [int];
  int run = 0, last_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit ewe;
      ewe = m_busy && m_scan < PB && ev[m_scan % PB];
      chk(busy == m_busy, "R9", "busy", busy, m_busy);
      chk(mem_we == ewe, "R3", "mem_we", mem_we, ewe);
      if (ewe && mem_we) begin
        chk(int'(mem_addr) == m_page * PB + m_scan, "R3", "mem_addr", mem_addr, m_page * PB + m_scan);
        chk(mem_data == ed[m_scan], "R3", "mem_data", mem_data, ed[m_scan]);
      end
      if (mem_we) mirror[int'(mem_addr)] = mem_data;
      if (busy) run++;
      else if (run != 0) begin last_len = run; run = 0; end
    end
  end

  task automatic bit_out(input logic b);
    @(negedge clk); sck = 0; mosi = b;
    @(negedge clk); @(negedge clk); sck = 1;
    @(negedge clk); @(negedge clk);
  endtask
  task automatic byte_out(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
  endtask
  task automatic fbegin();
    @(negedge clk); cs_n = 0; sck = 0;
    @(negedge clk); @(negedge clk);
  endtask
  task automatic fend();
    @(negedge clk); sck = 0;
    @(negedge clk); @(negedge clk); cs_n = 1;
    repeat (3) @(negedge clk);
  endtask
  task automatic wren();
    fbegin(); byte_out(8'h06); fend();
  endtask
  task automatic wr(input logic [15:0] a, input int n, input logic [7:0] base, input int extra);
    fbegin(); byte_out(8'h02); byte_out(a[15:8]); byte_out(a[7:0]);
    for (int i = 0; i < n; i++) byte_out(base + 8'(i));
    for (int i = 0; i < extra; i++) bit_out(1'b1);
    fend();
  endtask
  task automatic idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(mem_we == 0, "R1", "mem_we after reset", mem_we, 0);

    wr(16'h0100, 1, 8'h11, 0); idle();                                  // R1 R6
    chk(!mirror.exists(16'h0100), "R6", "write without enable", 1, 0);

    wren(); wr(16'h0123, 1, 8'h5A, 0); idle();                          // R2 R3
    chk(mirror.exists(16'h0123) && mirror[16'h0123] == 8'h5A, "R2", "enabled write", 0, 8'h5A);
    chk(last_len == WC, "R9", "busy length", last_len, WC);

    wr(16'h0130, 1, 8'h22, 0); idle();                                  // R10
    chk(!mirror.exists(16'h0130), "R10", "latch after cycle", 1, 0);

    wren(); wr(16'h023E, 4, 8'h01, 0); idle();                          // R5 wrap
    chk(mirror[16'h023E] == 8'h01 && mirror[16'h023F] == 8'h02, "R5", "page tail", mirror[16'h023F], 8'h02);
    chk(mirror[16'h0200] == 8'h03 && mirror[16'h0201] == 8'h04, "R5", "page head", mirror[16'h0201], 8'h04);

    wren(); wr(16'h0400, 66, 8'h80, 0); idle();                         // R5 overwrite
    chk(mirror[16'h0400] == 8'hC0 && mirror[16'h0401] == 8'hC1, "R5", "overwrite", mirror[16'h0400], 8'hC0);
    chk(mirror[16'h0402] == 8'h82, "R5", "untouched by wrap", mirror[16'h0402], 8'h82);

    wren(); wr(16'h0300, 1, 8'h33, 3); idle();                          // R4 partial byte
    chk(!mirror.exists(16'h0300), "R4", "off-boundary deselect", 1, 0);
    wr(16'h0300, 1, 8'h34, 0); idle();
    chk(!mirror.exists(16'h0300), "R4", "latch cleared by refusal", 1, 0);

    wren(); wr(16'h0500, 1, 8'h55, 0); wr(16'h0600, 1, 8'h66, 0); idle(); // R7
    chk(mirror[16'h0500] == 8'h55, "R7", "first write", mirror[16'h0500], 8'h55);
    chk(!mirror.exists(16'h0600), "R7", "write during busy", 1, 0);

    bp = 2'b01;
    wren(); wr(16'h6000, 1, 8'hA1, 0); idle();
    chk(!mirror.exists(16'h6000), "R8", "bp01 top quarter", 1, 0);
    wren(); wr(16'h5FC0, 1, 8'hA2, 0); idle();
    chk(mirror.exists(16'h5FC0), "R8", "bp01 below quarter", 0, 1);
    bp = 2'b10;
    wren(); wr(16'h4000, 1, 8'hA3, 0); idle();
    chk(!mirror.exists(16'h4000), "R8", "bp10 top half", 1, 0);
    bp = 2'b11;
    wren(); wr(16'h0010, 1, 8'hA4, 0); idle();
    chk(!mirror.exists(16'h0010), "R8", "bp11 all", 1, 0);
    bp = 2'b00;
    wren(); wr(16'h7FC0, 1, 8'hA5, 0); idle();
    chk(mirror.exists(16'h7FC0), "R8", "bp00 none", 0, 1);

    wren(); wr(16'h8045, 1, 8'h77, 0); idle();                          // R11
    chk(mirror.exists(16'h0045) && mirror[16'h0045] == 8'h77, "R11", "upper bit ignored", 0, 8'h77);

    wren();                                                             // R12
    fbegin(); byte_out(8'h03); byte_out(8'h07); byte_out(8'h00); byte_out(8'h99); fend(); idle();
    chk(!mirror.exists(16'h0700), "R12", "foreign opcode write", 1, 0);
    wr(16'h0710, 1, 8'h9A, 0); idle();
    chk(mirror.exists(16'h0710), "R12", "latch kept", 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule